// File: doc/BRIEF.md
# Stack-Bytecode Instruction Grouper

This block sits between instruction fetch and the execution back end of a stack machine whose instructions are one byte wide. It takes one 32-bit fetch word per cycle, splits it into four bytecodes and processes them low byte first. Each bytecode becomes a register-style micro-op. The slots of the shallow evaluation stack become fixed register numbers, and loads and stores of workspace locals name an entry of a workspace-cache register file. Consecutive micro-ops are collected into one issue group and handed to the back end as a unit.

When the back end can take a group, the open group leaves at once, so a word of simple operations reaches the back end one cycle after it was fetched. When the back end is busy, fetch keeps running and the open group keeps growing, so a stalled pipeline gets wider groups. Groups also close at a control transfer, at a stack fault, or when they are full. A counter limits how many issued groups may be unfinished at once. The back end reports each completed group with a one-cycle pulse.

Top module: `bc_grouper`

## Requirements
- R1: Synchronous active-high reset leaves no group on the output, `fetch_ready` high, the stack depth at zero, no pending prefix bits and an unfinished-group count of zero.
- R2: Bytes of a fetch word are taken from bits [7:0] upward. Each byte is a 4-bit function code (upper nibble) and a 4-bit operand nibble. Function code 0 is a prefix: it sets the accumulator to (accumulator OR nibble) shifted left by 4, truncated to OPW bits, and it yields no micro-op. Any other code uses operand = accumulator OR nibble, clears the accumulator and yields exactly one micro-op. Every such micro-op reaches the back end exactly once and in program order.
- R3: Function codes: 1 pushes a constant, 2 pushes a local, 3 pops into a local, 4 and 5 pop two and push one, 6 jumps, 7 pops and jumps conditionally, 8 to 15 leave the stack alone. With stack depth d before the op, p pops and u pushes: base = d - p; destination = base when u = 1, else 0; source A = base when p > 0, else 0; source B = d - 1 when p = 2, else 0. The new depth is base + u. Micro-op layout, high to low: function code [OPW+9:OPW+6], destination [OPW+5:OPW+4], source A [OPW+3:OPW+2], source B [OPW+1:OPW], operand [OPW-1:0].
- R4: For codes 2 and 3, the operand field is the workspace-cache index: operand modulo WSN (WSN is a power of two). All other codes carry the full operand.
- R5: A group holds 1 to GMAX micro-ops (count on `grp_count`, slot i in `grp_uops[i*UW +: UW]`). A group that reaches GMAX closes, and the next micro-op starts a new group.
- R6: A micro-op with function code 6 or 7 is always the last one in its group.
- R7: A pop with p > d, or a push that would make the depth exceed 3, is a stack fault. The faulting micro-op still joins its group, with all three register fields at zero. `grp_err` of that group is 1, the group closes after it, and the depth returns to 0.
- R8: When the output is free and the unfinished-group count is below MAXOUT, the open group is emitted at the same edge that takes in its bytes. A word of four non-prefix, non-closing bytecodes therefore appears as one group of four in the cycle after it is accepted.
- R9: While `grp_valid` is high and `be_accept` is low, the output group stays unchanged. Fetched bytecodes keep joining the open group until it closes.
- R10: At most MAXOUT groups are unfinished (emitted and not yet reported by a `be_done` pulse). At that limit no group is emitted. After a pulse, the next group can appear two edges later.
- R11: A closed group that cannot be emitted stops further bytecodes. The unprocessed bytes of the word are held, and `fetch_ready` stays low until they have been processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch word present |
| fetch_word | input | 32 | Four bytecodes, first one in bits [7:0] |
| fetch_ready | output | 1 | Word taken at this edge when valid |
| grp_valid | output | 1 | A group is on the output |
| grp_count | output | CW | Micro-ops in the group |
| grp_err | output | 1 | Group ends in a stack fault |
| grp_uops | output | GMAX*UW | Micro-op slots, slot 0 lowest |
| be_accept | input | 1 | Back end takes the output group at this edge |
| be_done | input | 1 | One issued group has completed |

## Verification
A group due to leave in the same edge that takes in its word is checked on the falling edge that follows. A group held while `be_accept` is low is checked on each falling edge until it is taken. A freed issue slot shows up as a new group two falling edges after the `be_done` pulse was driven, and the outstanding-limit check samples at that point. Group contents are compared when the bench hands them over with `be_accept`, against a micro-op queue built from the fetched bytes in program order. This comparison does not depend on the cycle in which a group formed, so the random back-end stalls never shift an expected value. The directed cases sample at the falling edges counted above.

// File: rtl/bc_grouper.sv
module bc_grouper #(
  parameter int GMAX   = 8,
  parameter int MAXOUT = 5,
  parameter int OPW    = 8,
  parameter int WSN    = 16,
  localparam int UW    = OPW + 10,
  localparam int CW    = $clog2(GMAX + 1),
  localparam int OCW   = $clog2(MAXOUT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_valid,
  input  logic [31:0]         fetch_word,
  output logic                fetch_ready,
  output logic                grp_valid,
  output logic [CW-1:0]       grp_count,
  output logic                grp_err,
  output logic [GMAX*UW-1:0]  grp_uops,
  input  logic                be_accept,
  input  logic                be_done
);

  logic [31:0]        wbuf, src;
  logic [2:0]         wleft, src_cnt, used;
  logic [OPW-1:0]     acc, n_acc, opnd, fop;
  logic [1:0]         depth, n_depth, dst, sa, sb;
  logic [CW-1:0]      gcnt, n_cnt, e_cnt;
  logic [GMAX*UW-1:0] guops, n_uops, e_uops;
  logic               gerr, n_err, e_err, gclosed, n_closed;
  logic               emit, stop, can_emit, bad;
  logic [OCW-1:0]     outst;
  logic [3:0]         fn, nb;
  logic [2:0]         dx, base, pops, push;

  assign fetch_ready = (wleft == 3'd0);
  assign src         = fetch_ready ? fetch_word : wbuf;
  assign src_cnt     = fetch_ready ? (fetch_valid ? 3'd4 : 3'd0) : wleft;
  assign can_emit    = (!grp_valid || be_accept) && (outst < OCW'(MAXOUT));

  always_comb begin
    n_cnt = gcnt;  n_uops = guops;  n_err = gerr;  n_closed = gclosed;
    n_depth = depth;  n_acc = acc;
    e_cnt = gcnt;  e_uops = guops;  e_err = gerr;
    emit = 1'b0;  stop = 1'b0;  used = 3'd0;
    fn = 4'd0;  nb = 4'd0;  opnd = '0;  fop = '0;
    dx = 3'd0;  base = 3'd0;  pops = 3'd0;  push = 3'd0;  bad = 1'b0;
    dst = 2'd0;  sa = 2'd0;  sb = 2'd0;

    if (n_closed) begin
      if (can_emit) begin
        emit = 1'b1;
        n_cnt = '0;  n_uops = '0;  n_err = 1'b0;  n_closed = 1'b0;
      end else begin
        stop = 1'b1;
      end
    end

    for (int k = 0; k < 4; k++) begin
      if (!stop && k < int'(src_cnt)) begin
        fn   = src[8*k+4 +: 4];
        nb   = src[8*k +: 4];
        used = 3'(k + 1);
        opnd = n_acc | OPW'(nb);
        if (fn == 4'd0) begin
          n_acc = opnd << 4;
        end else begin
          n_acc = '0;
          unique case (fn)
            4'd1, 4'd2: begin pops = 3'd0; push = 3'd1; end
            4'd3, 4'd7: begin pops = 3'd1; push = 3'd0; end
            4'd4, 4'd5: begin pops = 3'd2; push = 3'd1; end
            default:    begin pops = 3'd0; push = 3'd0; end
          endcase
          dx   = {1'b0, n_depth};
          base = dx - pops;
          bad  = (pops > dx) || (base + push > 3'd3);
          dst  = (!bad && push != 3'd0) ? base[1:0] : 2'd0;
          sa   = (!bad && pops != 3'd0) ? base[1:0] : 2'd0;
          sb   = (!bad && pops == 3'd2) ? 2'(dx - 3'd1) : 2'd0;
          fop  = (fn == 4'd2 || fn == 4'd3) ? (opnd & OPW'(WSN - 1)) : opnd;
          n_uops[int'(n_cnt)*UW +: UW] = {fn, dst, sa, sb, fop};
          n_cnt   = n_cnt + 1'b1;
          n_depth = bad ? 2'd0 : 2'(base + push);
          n_err   = n_err | bad;
          if (n_cnt == CW'(GMAX) || fn == 4'd6 || fn == 4'd7 || bad) begin
            if (can_emit && !emit) begin
              emit = 1'b1;
              e_cnt = n_cnt;  e_uops = n_uops;  e_err = n_err;
              n_cnt = '0;  n_uops = '0;  n_err = 1'b0;
            end else begin
              n_closed = 1'b1;
              stop = 1'b1;
            end
          end
        end
      end
    end

    if (!emit && can_emit && n_cnt != '0) begin
      emit = 1'b1;
      e_cnt = n_cnt;  e_uops = n_uops;  e_err = n_err;
      n_cnt = '0;  n_uops = '0;  n_err = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbuf <= '0;  wleft <= '0;  acc <= '0;  depth <= '0;
      gcnt <= '0;  guops <= '0;  gerr <= 1'b0;  gclosed <= 1'b0;
      grp_valid <= 1'b0;  grp_count <= '0;  grp_err <= 1'b0;  grp_uops <= '0;
      outst <= '0;
    end else begin
      wleft   <= src_cnt - used;
      wbuf    <= src >> (8 * used);
      acc     <= n_acc;
      depth   <= n_depth;
      gcnt    <= n_cnt;
      guops   <= n_uops;
      gerr    <= n_err;
      gclosed <= n_closed;
      if (emit) begin
        grp_valid <= 1'b1;
        grp_count <= e_cnt;
        grp_uops  <= e_uops;
        grp_err   <= e_err;
      end else if (be_accept) begin
        grp_valid <= 1'b0;
      end
      outst <= outst + OCW'(emit) - OCW'(be_done && outst != '0);
    end
  end

endmodule

// File: rtl/bc_grouper_chk.sv
module bc_grouper_chk #(
  parameter int GMAX   = 8,
  parameter int MAXOUT = 5,
  parameter int OPW    = 8,
  localparam int UW    = OPW + 10,
  localparam int CW    = $clog2(GMAX + 1),
  localparam int OCW   = $clog2(MAXOUT + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_ready,
  input logic               grp_valid,
  input logic [CW-1:0]      grp_count,
  input logic [GMAX*UW-1:0] grp_uops,
  input logic               be_accept,
  input logic               be_done,
  input logic [OCW-1:0]     outst
);

  function automatic logic early_close(input logic [GMAX*UW-1:0] u, input logic [CW-1:0] c);
    logic [3:0] f;
    early_close = 1'b0;
    for (int i = 0; i < GMAX; i++) begin
      f = u[i*UW + OPW + 6 +: 4];
      if (i + 1 < int'(c) && (f == 4'd6 || f == 4'd7)) early_close = 1'b1;
    end
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!grp_valid && fetch_ready && outst == '0));

  // R5
  group_size_chk: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> (grp_count != '0 && grp_count <= CW'(GMAX)));

  // R6
  jump_last_chk: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> !early_close(grp_uops, grp_count));

  // R9
  held_group_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !be_accept) |=> (grp_valid && $stable(grp_count) && $stable(grp_uops)));

  // R10
  outst_bound_chk: assert property (@(posedge clk) disable iff (rst)
    outst <= OCW'(MAXOUT));

  // R10
  outst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outst == OCW'(MAXOUT) && !be_done) |=> (outst == OCW'(MAXOUT)));

endmodule

bind bc_grouper bc_grouper_chk #(.GMAX(GMAX), .MAXOUT(MAXOUT), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .fetch_ready(fetch_ready), .grp_valid(grp_valid),
  .grp_count(grp_count), .grp_uops(grp_uops), .be_accept(be_accept),
  .be_done(be_done), .outst(outst)
);

// File: tb/bc_grouper_bench.sv
`timescale 1ns/1ps
module bc_grouper_bench;
  localparam int GMAX = 8, MAXOUT = 5, OPW = 8, WSN = 16;
  localparam int UW = OPW + 10;
  localparam int CW = $clog2(GMAX + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_valid = 1'b0, fetch_ready;
  logic [31:0] fetch_word = '0;
  logic grp_valid, grp_err;
  logic [CW-1:0] grp_count;
  logic [GMAX*UW-1:0] grp_uops;
  logic be_accept = 1'b0, be_done = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int acc_cnt = 0, done_cnt = 0;
  int m_depth = 0;
  logic [OPW-1:0] m_acc = '0;
  logic [UW-1:0] q_uop[$];
  logic          q_cls[$];
  logic          q_err[$];

  always #2.5 clk = ~clk;

  bc_grouper #(.GMAX(GMAX), .MAXOUT(MAXOUT), .OPW(OPW), .WSN(WSN)) u_bc_grouper (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .fetch_ready(fetch_ready), .grp_valid(grp_valid), .grp_count(grp_count),
    .grp_err(grp_err), .grp_uops(grp_uops), .be_accept(be_accept), .be_done(be_done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [UW-1:0] mk(input int f, input int d, input int a, input int b, input int op);
    return {4'(f), 2'(d), 2'(a), 2'(b), OPW'(op)};
  endfunction

  task automatic model_byte(input logic [7:0] b);
    int f, nbv, op, po, pu, bs, d, a, sbv;
    logic bd;
    f = int'(b[7:4]);  nbv = int'(b[3:0]);
    if (f == 0) begin
      m_acc = OPW'((int'(m_acc) | nbv) << 4);
    end else begin
      op = int'(m_acc) | nbv;  m_acc = '0;
      case (f)
        1, 2: begin po = 0; pu = 1; end
        3, 7: begin po = 1; pu = 0; end
        4, 5: begin po = 2; pu = 1; end
        default: begin po = 0; pu = 0; end
      endcase
      bd = (po > m_depth) || (m_depth - po + pu > 3);
      bs = m_depth - po;
      d = 0; a = 0; sbv = 0;
      if (!bd) begin
        if (pu == 1) d = bs;
        if (po > 0) a = bs;
        if (po == 2) sbv = m_depth - 1;
        m_depth = bs + pu;
      end else m_depth = 0;
      if (f == 2 || f == 3) op = op % WSN;
      q_uop.push_back(mk(f, d, a, sbv, op));
      q_cls.push_back(bd || f == 6 || f == 7);
      q_err.push_back(bd);
    end
  endtask

  task automatic check_group();
    logic anyerr = 1'b0;
    int c = int'(grp_count);
    logic [UW-1:0] got;
    chk(c >= 1 && c <= GMAX, "R5 group size", 64'(c), 64'(GMAX));
    for (int i = 0; i < c; i++) begin
      got = grp_uops[i*UW +: UW];
      if (q_uop.size() == 0) begin
        chk(1'b0, "R2 unexpected micro-op", 64'(got), 64'(0));
      end else begin
        chk(got == q_uop[0], "R2/R3/R4 micro-op", 64'(got), 64'(q_uop[0]));
        if (q_cls[0]) chk(i == c - 1, "R6/R7 closing op last", 64'(i), 64'(c - 1));
        anyerr = anyerr | q_err[0];
        void'(q_uop.pop_front()); void'(q_cls.pop_front()); void'(q_err.pop_front());
      end
    end
    chk(grp_err == anyerr, "R7 group error flag", 64'(grp_err), 64'(anyerr));
    acc_cnt++;
    chk(acc_cnt - done_cnt <= MAXOUT, "R10 unfinished groups", 64'(acc_cnt - done_cnt), 64'(MAXOUT));
  endtask

  task automatic cyc(input logic fv, input logic [31:0] w, input logic ac, input logic dn);
    fetch_valid = fv;  fetch_word = w;  be_accept = ac;
    be_done = dn && (acc_cnt > done_cnt);
    if (be_done) done_cnt++;
    if (grp_valid && be_accept) check_group();
    if (fetch_valid && fetch_ready)
      for (int k = 0; k < 4; k++) model_byte(w[8*k +: 8]);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;  fetch_valid = 1'b0;  be_accept = 1'b0;  be_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_depth = 0;  m_acc = '0;  acc_cnt = 0;  done_cnt = 0;
    q_uop.delete();  q_cls.delete();  q_err.delete();
    @(negedge clk);
    chk(!grp_valid, "R1 no group after reset", 64'(grp_valid), 64'(0));
    chk(fetch_ready, "R1 fetch ready after reset", 64'(fetch_ready), 64'(1));
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, 1'b1, 1'b1);
  endtask

  function automatic logic [UW-1:0] slot(input int i);
    return grp_uops[i*UW +: UW];
  endfunction

  function automatic logic [31:0] rand_word(input logic bias);
    logic [31:0] w;
    int f;
    for (int k = 0; k < 4; k++) begin
      if (bias && ($urandom % 10) < 6) f = 8 + int'($urandom % 8);
      else f = int'($urandom % 16);
      w[8*k +: 8] = {4'(f), 4'($urandom % 16)};
    end
    return w;
  endfunction

  localparam logic [31:0] PLAIN = 32'h84838281;

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R8, R3: four simple ops leave together one cycle later
    cyc(1'b1, 32'h13401211, 1'b1, 1'b0);
    chk(grp_valid && grp_count == 4, "R8 group of four next cycle", 64'(grp_count), 64'(4));
    chk(slot(2) == mk(4, 0, 0, 1, 0), "R3 add renamed", 64'(slot(2)), 64'(mk(4, 0, 0, 1, 0)));
    chk(slot(3) == mk(1, 1, 0, 0, 3), "R3 push renamed", 64'(slot(3)), 64'(mk(1, 1, 0, 0, 3)));
    drain(4);

    // R2, R4: prefix and workspace index
    do_reset();
    cyc(1'b1, 32'h81312A03, 1'b1, 1'b0);
    chk(grp_count == 3, "R2 prefix yields no op", 64'(grp_count), 64'(3));
    chk(slot(0) == mk(2, 0, 0, 0, 8'h0A), "R4 local load index", 64'(slot(0)), 64'(mk(2, 0, 0, 0, 8'h0A)));
    chk(slot(1) == mk(3, 0, 0, 0, 1), "R4 local store index", 64'(slot(1)), 64'(mk(3, 0, 0, 0, 1)));
    drain(4);

    // R6: jump closes its group
    do_reset();
    cyc(1'b1, 32'h83828165, 1'b1, 1'b0);
    chk(grp_count == 1 && slot(0) == mk(6, 0, 0, 0, 5), "R6 jump alone", 64'(grp_count), 64'(1));
    cyc(1'b0, 32'h0, 1'b1, 1'b1);
    chk(grp_valid && grp_count == 3, "R6 rest follows", 64'(grp_count), 64'(3));
    drain(4);

    // R7: underflow
    do_reset();
    cyc(1'b1, 32'h80181740, 1'b1, 1'b0);
    chk(grp_count == 1 && grp_err, "R7 fault closes group", 64'({grp_err, grp_count}), 64'({1'b1, 4'd1}));
    chk(slot(0) == mk(4, 0, 0, 0, 0), "R7 fault fields zero", 64'(slot(0)), 64'(mk(4, 0, 0, 0, 0)));
    cyc(1'b0, 32'h0, 1'b1, 1'b1);
    chk(grp_count == 3 && !grp_err, "R7 next group clean", 64'({grp_err, grp_count}), 64'({1'b0, 4'd3}));
    chk(slot(0) == mk(1, 0, 0, 0, 7), "R7 depth back to zero", 64'(slot(0)), 64'(mk(1, 0, 0, 0, 7)));
    drain(4);

    // R9, R5, R11: busy back end grows the open group
    do_reset();
    cyc(1'b1, PLAIN, 1'b0, 1'b0);
    cyc(1'b1, PLAIN, 1'b0, 1'b0);
    cyc(1'b1, PLAIN, 1'b0, 1'b0);
    cyc(1'b1, PLAIN, 1'b0, 1'b0);
    chk(grp_count == 4, "R9 held group unchanged", 64'(grp_count), 64'(4));
    chk(!fetch_ready, "R11 backpressure on leftover", 64'(fetch_ready), 64'(0));
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    chk(grp_valid && grp_count == GMAX, "R5 full group of eight", 64'(grp_count), 64'(GMAX));
    chk(fetch_ready, "R11 ready after leftover used", 64'(fetch_ready), 64'(1));
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    chk(grp_valid && grp_count == 4, "R5 next group after full", 64'(grp_count), 64'(4));
    drain(6);

    // R10: issue limit
    do_reset();
    for (int i = 0; i < 6; i++) cyc(1'b1, PLAIN, 1'b1, 1'b0);
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    chk(!grp_valid, "R10 no issue at limit", 64'(grp_valid), 64'(0));
    cyc(1'b0, 32'h0, 1'b1, 1'b1);
    chk(!grp_valid, "R10 slot not yet free", 64'(grp_valid), 64'(0));
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    chk(grp_valid && grp_count == 4, "R10 issue after done", 64'(grp_count), 64'(4));
    drain(12);

    // Random: R2..R11 against the queue model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic bias = (i / 200) % 2 == 1;
      cyc(($urandom % 4) != 0, rand_word(bias), ($urandom % 10) < 6, ($urandom % 3) == 0);
    end
    drain(80);
    chk(q_uop.size() == 0, "R2 every micro-op delivered", 64'(q_uop.size()), 64'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule